// File: doc/BRIEF.md
# Swept-Tone Phase Sequencer

This block produces the running phase of an excitation tone and walks that tone through a stepped frequency sweep under explicit command control. A byte-wide write port fills three shadow values: a start tuning code, a step tuning code and a point limit. A start command copies them into the live sweep state and clears the phase. From then on a 27-bit accumulator adds the live tuning word once every four clocks.

An increment command moves the tone up by one step. A repeat command keeps the tone where it is so the current point can be measured again. An external measurement engine reports the end of each point on `meas_done`. Two flags in a status byte tell the controller that a point has finished and that the whole sweep has finished. Once the sweep has finished, further increments are refused until the next start.

Commands arrive on a valid/ready pair. `cmd_ready` is low only while `rst` is high. A command is taken on any clock edge where both `cmd_valid` and `cmd_ready` are high. The sender keeps `cmd_valid` and `cmd_code` steady until that edge. Every accepted command is consumed in that single cycle.

Top module: `sweep_seq`

## Requirements
- R1: While `rst` is high on a clock edge, `phase`, `phase_word` and `status` are zero after that edge, and `cmd_ready` is low during reset.
- R2: Write offsets are as follows. Offsets 0, 1 and 2 hold the start code, most significant byte first. Offsets 3, 4 and 5 hold the step code, most significant byte first. Offset 6 holds the upper bit of the 9-bit point limit in its bit 0, and offset 7 holds the lower 8 bits. Written values affect the tone only after the next accepted start.
- R3: An accepted start (`cmd_code` 2'b01) loads the tuning word with the 24-bit start code, upper 3 bits zero. It also clears the phase, the point counter and both status flags.
- R4: After a start, the phase grows by the tuning word once every 4 clocks, modulo 2^27. The first growth happens 4 clocks after the start edge.
- R5: When the point counter is below the limit and the sweep is not finished, an accepted increment (`cmd_code` 2'b10) adds the step code to the tuning word and advances the point counter.
- R6: An accepted repeat (`cmd_code` 2'b11) leaves the tuning word unchanged and clears the point-done flag.
- R7: A `meas_done` pulse while a sweep is running sets the point-done flag, which is `status` bit 2. An accepted start, increment or repeat clears this flag. All other status bits are zero.
- R8: An increment that arrives while the point counter equals the limit sets the sweep-done flag, which is `status` bit 3. It does not change the tuning word. With a limit of 0, the first increment after a start does this.
- R9: While the sweep-done flag is set, increments are ignored: the tuning word and point-done flag keep their values until the next start.
- R10: Before the first start after reset, commands and `meas_done` have no effect: the phase stays zero and `status` stays zero.
- R11: `phase_word` equals the upper 10 bits of `phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 4 | Shadow register byte offset |
| wr_data | input | 8 | Write byte |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (low in reset) |
| cmd_code | input | 2 | 00 none, 01 start, 10 increment, 11 repeat |
| meas_done | input | 1 | Measurement of the current point finished |
| phase | output | 27 | Accumulator phase |
| phase_word | output | 10 | Truncated phase for a sine lookup |
| status | output | 8 | Bit 2 point done, bit 3 sweep done |

## Verification
A wrong tuning word shows up within four clocks as a wrong phase step. Measuring the phase difference across any four-clock window exposes it no matter where the prescaler stands. A wrong point counter or limit stays hidden until the increment that should end the sweep. At that point, `status` bit 3 is missing or comes early, and the phase step shows whether the refused increment still moved the tone. A stuck or badly cleared point-done flag is visible on `status` in the cycle after the command or pulse that should change it.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_START = 2'b01,
    CMD_INC   = 2'b10,
    CMD_REP   = 2'b11
  } cmd_e;
endpackage

// File: rtl/sweep_regs.sv
// Shadow values written byte by byte; most significant byte at lowest offset.
module sweep_regs #(
  parameter int CODE_W = 24,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CODE_W-1:0] start_code,
  output logic [CODE_W-1:0] step_code,
  output logic [CNT_W-1:0]  limit_code
);
  localparam int NB       = CODE_W / 8;
  localparam int STEP_OFF = NB;
  localparam int LIM_OFF  = 2 * NB;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_code <= '0;
      step_code  <= '0;
      limit_code <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_addr == ADDR_W'(b))
          start_code[CODE_W-1-8*b -: 8] <= wr_data;
        if (wr_addr == ADDR_W'(STEP_OFF + b))
          step_code[CODE_W-1-8*b -: 8] <= wr_data;
      end
      if (wr_addr == ADDR_W'(LIM_OFF))
        limit_code[CNT_W-1:8] <= wr_data[CNT_W-9:0];
      if (wr_addr == ADDR_W'(LIM_OFF + 1))
        limit_code[7:0] <= wr_data;
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
// Sweep state: live tuning word, point counter and the two status flags.
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int ACC_W  = 27,
  parameter int CODE_W = 24,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  cmd_e              cmd,
  input  logic              meas_done,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] step_code,
  input  logic [CNT_W-1:0]  limit_code,
  output logic [ACC_W-1:0]  tuning,
  output logic              running,
  output logic              start_fire,
  output logic              point_done,
  output logic              sweep_done
);
  localparam int PAD_W = ACC_W - CODE_W;

  logic [CODE_W-1:0] step_q;
  logic [CNT_W-1:0]  lim_q, cnt_q;
  logic              inc_fire, rep_fire;

  assign start_fire = cmd_fire && (cmd == CMD_START);
  assign inc_fire   = cmd_fire && (cmd == CMD_INC);
  assign rep_fire   = cmd_fire && (cmd == CMD_REP);

  always_ff @(posedge clk) begin
    if (rst) begin
      tuning     <= '0;
      step_q     <= '0;
      lim_q      <= '0;
      cnt_q      <= '0;
      running    <= 1'b0;
      point_done <= 1'b0;
      sweep_done <= 1'b0;
    end else if (start_fire) begin
      tuning     <= {{PAD_W{1'b0}}, start_code};
      step_q     <= step_code;
      lim_q      <= limit_code;
      cnt_q      <= '0;
      running    <= 1'b1;
      point_done <= 1'b0;
      sweep_done <= 1'b0;
    end else if (running) begin
      if (inc_fire && !sweep_done) begin
        point_done <= 1'b0;
        if (cnt_q == lim_q) begin
          sweep_done <= 1'b1;
        end else begin
          tuning <= tuning + {{PAD_W{1'b0}}, step_q};
          cnt_q  <= cnt_q + 1'b1;
        end
      end else if (rep_fire) begin
        point_done <= 1'b0;
      end
      if (meas_done) point_done <= 1'b1;
    end
  end

  // R8
  sweep_end_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sweep_done) |-> $past(inc_fire));
  // R9
  sweep_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && !start_fire) |=> (sweep_done && $stable(tuning)));
  // R7
  point_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(point_done) |-> $past(meas_done));
  // R6
  repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rep_fire |=> $stable(tuning));
endmodule

// File: rtl/phase_acc.sv
// Phase accumulator advancing once every DIV clocks.
module phase_acc #(
  parameter int ACC_W = 27,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [ACC_W-1:0] tuning,
  output logic [ACC_W-1:0] phase
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
      phase <= '0;
    end else if (run) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        phase <= phase + tuning;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && pre_q != PRE_LAST) |=> (phase == $past(phase)));
  // R3
  phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (phase == '0));
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int ACC_W  = 27,
  parameter int CODE_W = 24,
  parameter int CNT_W  = 9,
  parameter int DIV    = 4,
  parameter int PW     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_code,
  input  logic             meas_done,
  output logic [ACC_W-1:0] phase,
  output logic [PW-1:0]    phase_word,
  output logic [7:0]       status
);
  logic [CODE_W-1:0] start_code, step_code;
  logic [CNT_W-1:0]  limit_code;
  logic [ACC_W-1:0]  tuning;
  logic              running, start_fire, point_done, sweep_done, cmd_fire;

  assign cmd_ready = !rst;
  assign cmd_fire  = cmd_valid && cmd_ready;

  sweep_regs #(.CODE_W(CODE_W), .CNT_W(CNT_W), .ADDR_W(4)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_code(start_code), .step_code(step_code), .limit_code(limit_code)
  );

  sweep_ctrl #(.ACC_W(ACC_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd(cmd_e'(cmd_code)),
    .meas_done(meas_done), .start_code(start_code), .step_code(step_code),
    .limit_code(limit_code), .tuning(tuning), .running(running),
    .start_fire(start_fire), .point_done(point_done), .sweep_done(sweep_done)
  );

  phase_acc #(.ACC_W(ACC_W), .DIV(DIV)) u_acc (
    .clk(clk), .rst(rst), .clear(start_fire), .run(running),
    .tuning(tuning), .phase(phase)
  );

  assign phase_word = phase[ACC_W-1 -: PW];
  assign status     = {4'b0000, sweep_done, point_done, 2'b00};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase == '0 && status == 8'h00));
  // R7
  status_spare_chk: assert property (@(posedge clk) disable iff (rst)
    (status[7:4] == 4'h0 && status[1:0] == 2'b00));
endmodule

// File: tb/test_sweep_seq.sv
module test_sweep_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_code = 2'b00;
  logic        meas_done = 1'b0;
  logic [26:0] phase;
  logic [9:0]  phase_word;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit busy = 0;
  logic [26:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sweep_seq i_sweep_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .meas_done(meas_done), .phase(phase), .phase_word(phase_word), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [23:0] s, input logic [23:0] st, input logic [8:0] n);
    wr(4'd0, s[23:16]); wr(4'd1, s[15:8]); wr(4'd2, s[7:0]);
    wr(4'd3, st[23:16]); wr(4'd4, st[15:8]); wr(4'd5, st[7:0]);
    wr(4'd6, {7'b0, n[8]}); wr(4'd7, n[7:0]);
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 2'b00;
  endtask

  task automatic pulse_meas();
    @(negedge clk); meas_done = 1'b1;
    @(negedge clk); meas_done = 1'b0;
  endtask

  // driver side of the scoreboard: queue an expected step, wait until judged
  task automatic expect_step(input logic [26:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk);
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  // monitor: measures phase growth over a 4-clock window
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [26:0] p0, ev;
        string tg;
        busy = 1'b1;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        p0 = phase;
        repeat (4) @(negedge clk);
        chk(tg, 32'(phase - p0), 32'(ev));
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [26:0] t;
    repeat (3) @(negedge clk);
    chk("R1 ready low", 32'(cmd_ready), 32'd0);
    chk("R1 phase", 32'(phase), 32'd0);
    chk("R1 status", 32'(status), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after", 32'(cmd_ready), 32'd1);

    // R10: nothing happens before the first start
    load(24'h0F5C28, 24'h00014F, 9'd3);
    cmd(2'b10); cmd(2'b11); pulse_meas();
    repeat (8) @(negedge clk);
    chk("R10 phase idle", 32'(phase), 32'd0);
    chk("R10 status idle", 32'(status), 32'd0);

    // R3/R4: start, exact phase after 8 clocks
    cmd(2'b01);
    chk("R3 status clear", 32'(status), 32'd0);
    repeat (8) @(negedge clk);
    chk("R4 phase after two steps", 32'(phase), 32'(27'h0F5C28 * 2));
    chk("R11 phase_word", 32'(phase_word), 32'(phase[26:17]));
    expect_step(27'h0F5C28, "R2 R3 start tuning");

    // R7/R6
    pulse_meas();
    chk("R7 point flag set", 32'(status), 32'h04);
    cmd(2'b11);
    chk("R6 repeat clears flag", 32'(status), 32'h00);
    expect_step(27'h0F5C28, "R6 repeat keeps tone");

    // R2: mid-sweep writes have no effect until a start
    load(24'h123456, 24'h000010, 9'd0);
    expect_step(27'h0F5C28, "R2 shadow not live");

    // R5: three increments reach the limit of 3
    t = 27'h0F5C28;
    pulse_meas();
    cmd(2'b10);
    chk("R7 inc clears flag", 32'(status), 32'h00);
    t = t + 27'h14F;
    expect_step(t, "R5 first increment");
    cmd(2'b10); cmd(2'b10);
    t = t + 27'h29E;
    expect_step(t, "R5 third increment");
    chk("R8 not yet done", 32'(status), 32'h00);

    // R8: increment at limit ends the sweep, tone unchanged
    cmd(2'b10);
    chk("R8 sweep flag", 32'(status), 32'h08);
    expect_step(t, "R8 tone held");

    // R9: increments ignored after completion
    pulse_meas();
    chk("R7 flag with sweep done", 32'(status), 32'h0C);
    cmd(2'b10);
    chk("R9 flags unchanged", 32'(status), 32'h0C);
    expect_step(t, "R9 tone unchanged");

    // R2/R8: restart picks up new shadow values, limit 0 ends on first increment
    cmd(2'b01);
    chk("R3 restart clears", 32'(status), 32'h00);
    expect_step(27'h123456, "R2 new start live");
    cmd(2'b10);
    chk("R8 zero limit", 32'(status), 32'h08);
    expect_step(27'h123456, "R8 zero limit tone");

    // R4 wrap with largest code
    load(24'hFFFFFF, 24'hFFFFFF, 9'd511);
    cmd(2'b01);
    repeat (40) @(negedge clk);
    expect_step(27'hFFFFFF, "R4 wrapping step");
    cmd(2'b10);
    expect_step(27'h1FFFFFE, "R5 large increment");
    chk("R11 phase_word late", 32'(phase_word), 32'(phase[26:17]));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule